// File: doc/BRIEF.md
# Odd-Forced NCO Phase Accumulator

This block is the phase engine of a numerically controlled oscillator. Each sample strobe adds a frequency tuning word to a wide accumulator. The accumulator wraps modulo 2^ACC_W. The block then presents the upper PHASE_W bits of the new accumulator value to the downstream phase-to-amplitude stage. The bits below are dropped by truncation.

The block lowers truncation spurs with a one-bit toggle. On every second sample it feeds an extra 1 into the carry input of the adder. Over each pair of samples the accumulator therefore advances by twice the tuning word plus one, which is always odd. The oscillator behaves as if the tuning word's lowest bit were set, at the cost of a frequency offset of half an accumulator LSB. As a result, every tuning word and every starting state makes the accumulator run through the full set of 2^ACC_W values. This makes the spur floor independent of the tuning word, at about 6 dB per bit of PHASE_W.

The output side is a stream with no back-pressure. `phase_valid` marks each new phase word for one cycle, and the consumer must accept it in that cycle. The sample strobe acts as the input valid, and the block is always ready for it.

Top module: `nco_phase_acc`

## Requirements
- R1: While `rst` is high at a clock edge, the accumulator, the toggle bit and `phase_out` are cleared to zero and `phase_valid` is driven low from that edge on.
- R2: At each edge where `sample_en` is high and `phase_clr` is low, the accumulator becomes acc + ftw + t modulo 2^ACC_W. Here t is the toggle bit. It is 0 for the first sample after reset or clear and inverts at every such sample.
- R3: After a sample edge, `phase_out` equals bits [ACC_W-1 : ACC_W-PHASE_W] of the updated accumulator and `phase_valid` is high for exactly that one cycle.
- R4: At an edge with `sample_en` low and `phase_clr` low, the accumulator, the toggle and `phase_out` hold their values, and `phase_valid` is low in the following cycle.
- R5: The sum wraps modulo 2^ACC_W with no saturation. From zero with ftw all ones, the first sample gives an accumulator of all ones and the second gives all ones again.
- R6: A change of `ftw` between strobes does not alter the accumulator or `phase_out`. The new word is used from the next strobe on.
- R7: At an edge with `phase_clr` high, the accumulator, the toggle and `phase_out` become zero and `phase_valid` goes low. A strobe in the same cycle is ignored.
- R8: Take 2^(ACC_W+1) consecutive strobes from a clear, with any tuning word including zero and even words. The accumulator values after the even-numbered strobes are all 2^ACC_W distinct values. Each `phase_out` code therefore appears exactly 2^(ACC_W-PHASE_W) times at those strobes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| sample_en | input | 1 | Sample strobe (stream valid in) |
| ftw | input | ACC_W | Frequency tuning word |
| phase_clr | input | 1 | Synchronous clear of phase and toggle |
| phase_out | output | PHASE_W | Truncated phase word |
| phase_valid | output | 1 | New phase word this cycle |

## Verification
A wrong toggle bit or a lost carry first changes only the low, truncated accumulator bits. The error can therefore stay hidden at `phase_out` for up to 2^(ACC_W-PHASE_W) samples before it reaches the visible bits. For this reason the bench uses a narrow accumulator and compares every sample over full periods. It also counts how often each phase code appears, so that a step that is off by one shows up as uneven counts, even where individual words still happen to match. A fault in the valid or hold logic shows up one cycle after the edge concerned.

// File: rtl/nco_pkg.sv
package nco_pkg;
  typedef enum logic [1:0] {
    ACT_IDLE  = 2'd0,
    ACT_STEP  = 2'd1,
    ACT_CLEAR = 2'd2
  } acc_act_e;

  function automatic acc_act_e decode_act(input logic clr, input logic en);
    if (clr)     return ACT_CLEAR;
    else if (en) return ACT_STEP;
    else         return ACT_IDLE;
  endfunction
endpackage

// File: rtl/nco_lsb_toggle.sv
module nco_lsb_toggle
  import nco_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  acc_act_e act,
  output logic     tog
);
  always_ff @(posedge clk) begin
    if (rst)                  tog <= 1'b0;
    else if (act == ACT_CLEAR) tog <= 1'b0;
    else if (act == ACT_STEP)  tog <= ~tog;
  end

  // R2: toggle inverts on every sample
  a_r2_toggle_flips: assert property (@(posedge clk) disable iff (rst)
    (act == ACT_STEP) |=> (tog != $past(tog)));
  // R4: toggle holds when idle
  a_r4_toggle_hold: assert property (@(posedge clk) disable iff (rst)
    (act == ACT_IDLE) |=> $stable(tog));
endmodule

// File: rtl/nco_seg_adder.sv
module nco_seg_adder #(
  parameter int ACC_W = 64,
  parameter int SEG_W = 16
) (
  input  logic [ACC_W-1:0] a,
  input  logic [ACC_W-1:0] b,
  input  logic             cin,
  output logic [ACC_W-1:0] sum
);
  localparam int NSEG = ACC_W / SEG_W;

  logic [NSEG:0] carry;
  assign carry[0] = cin;

  for (genvar g = 0; g < NSEG; g++) begin : g_seg
    logic [SEG_W:0] part;
    assign part = {1'b0, a[g*SEG_W +: SEG_W]} + {1'b0, b[g*SEG_W +: SEG_W]}
                + {{SEG_W{1'b0}}, carry[g]};
    assign sum[g*SEG_W +: SEG_W] = part[SEG_W-1:0];
    assign carry[g+1] = part[SEG_W];
  end

  // carry out of the top segment is dropped: modulo 2^ACC_W wrap (R5)
  logic unused_cout;
  assign unused_cout = carry[NSEG];

  initial begin
    a_r5_seg_divides: assert (ACC_W % SEG_W == 0);
  end
endmodule

// File: rtl/nco_phase_reg.sv
module nco_phase_reg
  import nco_pkg::*;
#(
  parameter int PHASE_W = 32
) (
  input  logic               clk,
  input  logic               rst,
  input  acc_act_e           act,
  input  logic [PHASE_W-1:0] phase_next,
  output logic [PHASE_W-1:0] phase_out,
  output logic               phase_valid
);
  always_ff @(posedge clk) begin
    if (rst || act == ACT_CLEAR) begin
      phase_out   <= '0;
      phase_valid <= 1'b0;
    end else if (act == ACT_STEP) begin
      phase_out   <= phase_next;
      phase_valid <= 1'b1;
    end else begin
      phase_valid <= 1'b0;
    end
  end

  // R3: valid exactly one cycle after a sample
  a_r3_valid_after_step: assert property (@(posedge clk) disable iff (rst)
    (act == ACT_STEP) |=> phase_valid);
  a_r3_no_valid_otherwise: assert property (@(posedge clk) disable iff (rst)
    (act != ACT_STEP) |=> !phase_valid);
  // R4: output held while idle
  a_r4_phase_hold: assert property (@(posedge clk) disable iff (rst)
    (act == ACT_IDLE) |=> $stable(phase_out));
endmodule

// File: rtl/nco_phase_acc.sv
module nco_phase_acc
  import nco_pkg::*;
#(
  parameter int ACC_W   = 64,
  parameter int PHASE_W = 32,
  parameter int SEG_W   = 16
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               sample_en,
  input  logic [ACC_W-1:0]   ftw,
  input  logic               phase_clr,
  output logic [PHASE_W-1:0] phase_out,
  output logic               phase_valid
);
  localparam int TOP_LSB = ACC_W - PHASE_W;

  acc_act_e         act;
  logic             tog;
  logic [ACC_W-1:0] acc_q;
  logic [ACC_W-1:0] acc_next;

  assign act = decode_act(phase_clr, sample_en);

  nco_lsb_toggle u_tog (
    .clk (clk),
    .rst (rst),
    .act (act),
    .tog (tog)
  );

  nco_seg_adder #(.ACC_W(ACC_W), .SEG_W(SEG_W)) u_add (
    .a   (acc_q),
    .b   (ftw),
    .cin (tog),
    .sum (acc_next)
  );

  always_ff @(posedge clk) begin
    if (rst || act == ACT_CLEAR) acc_q <= '0;
    else if (act == ACT_STEP)   acc_q <= acc_next;
  end

  nco_phase_reg #(.PHASE_W(PHASE_W)) u_out (
    .clk         (clk),
    .rst         (rst),
    .act         (act),
    .phase_next  (acc_next[ACC_W-1:TOP_LSB]),
    .phase_out   (phase_out),
    .phase_valid (phase_valid)
  );

  // R2: accumulator step includes tuning word and toggle bit
  a_r2_step_sum: assert property (@(posedge clk) disable iff (rst)
    (act == ACT_STEP) |=> (acc_q == ACC_W'($past(acc_q) + $past(ftw) + ACC_W'($past(tog)))));
  // R4: accumulator holds while idle
  a_r4_acc_hold: assert property (@(posedge clk) disable iff (rst)
    (act == ACT_IDLE) |=> $stable(acc_q));
  // R7: clear zeroes accumulator and toggle
  a_r7_clear_zero: assert property (@(posedge clk) disable iff (rst)
    phase_clr |=> (acc_q == '0 && !tog && !phase_valid));
  // R3: output tracks top bits of the accumulator after a sample
  a_r3_phase_top: assert property (@(posedge clk) disable iff (rst)
    phase_valid |-> (phase_out == acc_q[ACC_W-1:TOP_LSB]));
endmodule

// File: tb/tb_nco_phase_acc.sv
module tb_nco_phase_acc;
  localparam int CLK_PERIOD = 10;
  localparam int N = 10;
  localparam int W = 4;
  localparam int S = 5;
  localparam int NBIN = 1 << W;
  localparam int PERIOD2 = 1 << (N + 1);

  logic         clk = 1'b0;
  logic         rst;
  logic         sample_en;
  logic [N-1:0] ftw;
  logic         phase_clr;
  logic [W-1:0] phase_out;
  logic         phase_valid;

  int n_tests = 0;
  int n_fail  = 0;
  logic [N-1:0] exp_acc;
  logic         exp_tog;

  always #(CLK_PERIOD/2) clk = ~clk;

  nco_phase_acc #(.ACC_W(N), .PHASE_W(W), .SEG_W(S)) dut (
    .clk(clk), .rst(rst), .sample_en(sample_en), .ftw(ftw),
    .phase_clr(phase_clr), .phase_out(phase_out), .phase_valid(phase_valid)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // one cycle: drive at negedge, check just after the posedge
  task automatic cyc(input logic en, input logic clr, input string req);
    @(negedge clk);
    sample_en = en; phase_clr = clr;
    @(posedge clk);
    #1;
    if (clr) begin
      exp_acc = '0; exp_tog = 1'b0;
      chk(phase_out == 0, req, phase_out, 0);
      chk(phase_valid == 1'b0, req, phase_valid, 0);
    end else if (en) begin
      exp_acc = exp_acc + ftw + N'(exp_tog);
      exp_tog = ~exp_tog;
      chk(phase_out == exp_acc[N-1 -: W], req, phase_out, exp_acc[N-1 -: W]);
      chk(phase_valid == 1'b1, req, phase_valid, 1);
    end else begin
      chk(phase_out == exp_acc[N-1 -: W], req, phase_out, exp_acc[N-1 -: W]);
      chk(phase_valid == 1'b0, req, phase_valid, 0);
    end
    sample_en = 1'b0; phase_clr = 1'b0;
  endtask

  task automatic full_period(input logic [N-1:0] word);
    int hist [NBIN];
    for (int b = 0; b < NBIN; b++) hist[b] = 0;
    ftw = word;
    cyc(1'b0, 1'b1, "R7");
    for (int k = 1; k <= PERIOD2; k++) begin
      cyc(1'b1, 1'b0, "R2/R3");
      if (k % 2 == 0) hist[phase_out]++;
    end
    // R8: every phase code equally often at the even strobes
    for (int b = 0; b < NBIN; b++)
      chk(hist[b] == (1 << (N - W)), "R8", hist[b], 1 << (N - W));
  endtask

  initial begin
    int wd = 0;
    forever begin
      @(posedge clk);
      wd++;
      if (wd > 150000) begin
        n_fail++; n_tests++;
        $display("FAIL watchdog: actual %0d expected %0d", wd, 150000);
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
      end
    end
  end

  initial begin
    rst = 1'b1; sample_en = 1'b0; phase_clr = 1'b0; ftw = '0;
    exp_acc = '0; exp_tog = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    chk(phase_out == 0, "R1", phase_out, 0);
    chk(phase_valid == 0, "R1", phase_valid, 0);
    @(negedge clk); rst = 1'b0;

    // R4: idle cycles hold output and keep valid low
    ftw = 10'd37;
    cyc(1'b1, 1'b0, "R2");
    cyc(1'b1, 1'b0, "R2");
    cyc(1'b1, 1'b0, "R2");
    repeat (4) cyc(1'b0, 1'b0, "R4");
    cyc(1'b1, 1'b0, "R4");

    // R6: tuning word change between strobes does nothing until next strobe
    cyc(1'b0, 1'b1, "R7");
    ftw = 10'd5;
    cyc(1'b1, 1'b0, "R6");
    ftw = 10'd300;
    cyc(1'b0, 1'b0, "R6");
    cyc(1'b0, 1'b0, "R6");
    cyc(1'b1, 1'b0, "R6");
    chk(exp_acc == 10'd306, "R6", exp_acc, 306);

    // R5: wrap with all-ones tuning word
    ftw = '1;
    cyc(1'b0, 1'b1, "R7");
    cyc(1'b1, 1'b0, "R5");
    chk(phase_out == 4'hF, "R5", phase_out, 15);
    cyc(1'b1, 1'b0, "R5");
    chk(phase_out == 4'hF, "R5", phase_out, 15);
    cyc(1'b1, 1'b0, "R5");

    // R7: clear together with a strobe; clear wins
    ftw = 10'd200;
    cyc(1'b1, 1'b0, "R2");
    cyc(1'b1, 1'b1, "R7");
    cyc(1'b1, 1'b0, "R7");
    chk(phase_out == 4'(200 >> 6), "R7", phase_out, 200 >> 6);

    // R1: reset in mid-run clears state
    cyc(1'b1, 1'b0, "R2");
    @(negedge clk); rst = 1'b1;
    @(posedge clk); #1;
    chk(phase_out == 0, "R1", phase_out, 0);
    chk(phase_valid == 0, "R1", phase_valid, 0);
    @(negedge clk); rst = 1'b0;
    exp_acc = '0; exp_tog = 1'b0;
    cyc(1'b1, 1'b0, "R1");

    // R8: full periods for zero, even, odd, all-ones and MSB-only words
    full_period(10'd0);
    full_period(10'd4);
    full_period(10'd1);
    full_period(10'h3FF);
    full_period(10'h200);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule